// File: doc/BRIEF.md
# Sync-Referenced Line Pulse Generator

This block runs on the video pixel clock and follows a detected horizontal sync input. On each falling edge of that sync it restarts a per-line counter and, from that counter, produces two strobes at the line rate. The drive strobe starts with the count and ends at a programmable 10-bit time. The restore strobe is meant for an input clamp. It opens at a programmable 10-bit start time and stays open for a fixed number of clocks set by a parameter.

Both 10-bit times are split across a pair of byte registers. A low byte register holds bits 7:0 and a high byte register holds bits 9:8. The unused upper bits of each high byte register are masked. Values that are written take effect only at the next sync falling edge, so a pulse already under way keeps its length.

Top module: `line_pulse_gen`

## Requirements
- R1: After reset, address 0x0E reads 0x20, 0x0F reads 0x00, 0x12 reads 0x37 and 0x13 reads 0x00. Both strobes stay low until the first sync falling edge.
- R2: Address 0x0E holds drive end bits 7:0 and address 0x0F holds bits 9:8 in its data bits 1:0. Address 0x12 holds restore start bits 7:0 and address 0x13 holds bits 9:8 in its data bits 1:0. Data bits 7:2 of 0x0F and 0x13 ignore writes and read 0. Any other address reads 0x00.
- R3: A falling edge of `hsync_in` is sampled at clock edge P0. The counter becomes 0 at edge P1 and then rises by one per clock, so its value after edge P(1+k) is k.
- R4: `drive_out` is high exactly while the count k is below the active end time E, which gives E clocks. When E is 0 there is no pulse.
- R5: `restore_out` is high while k is at least the active start time S and below S plus RESTORE_W (default 16).
- R6: Without a new falling edge the count stops at 1023. At the stopped value `restore_out` is low and no strobe starts again.
- R7: A register write changes nothing in the line under way. The new value is used from the next falling edge on.
- R8: A rising edge of `hsync_in`, or `hsync_in` held low, does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Detected horizontal sync, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| drive_out | output | 1 | Drive strobe |
| restore_out | output | 1 | Clamp/restore strobe |

## Verification
On every cycle, the assertions check how the counter behaves: it restarts one clock after a detected edge, climbs by one and holds at its ceiling. They also check that no two restarts are adjacent and that each strobe edge lands at the count its active setting names. Only the bench scenarios can show the reset and readback values, the masking of the upper bits, and the exact length of each strobe against an independent model. The same applies to a pulse left unshortened by a write in mid-line, and to the count stopping across a long run with no sync.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
   localparam logic [7:0] ADDR_DRV_LO = 8'h0E;
   localparam logic [7:0] ADDR_DRV_HI = 8'h0F;
   localparam logic [7:0] ADDR_RST_LO = 8'h12;
   localparam logic [7:0] ADDR_RST_HI = 8'h13;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lpg_regs.sv
module lpg_regs
   import lpg_pkg::*;
#(
   parameter int CNT_W      = 10,
   parameter int DRV_RESET  = 32,
   parameter int RST_RESET  = 55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  byte_t            addr,
   input  byte_t            wdata,
   output byte_t            rdata,
   output logic [CNT_W-1:0] drv_end,
   output logic [CNT_W-1:0] rst_start
);
   localparam int HI_W = CNT_W - BYTE_W;

   initial begin
      if (HI_W < 1 || HI_W > BYTE_W) $error("lpg_regs: CNT_W must be 9..16");
   end

   logic [CNT_W-1:0] end_q, start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         end_q   <= CNT_W'(DRV_RESET);
         start_q <= CNT_W'(RST_RESET);
      end else if (we) begin
         case (addr)
            ADDR_DRV_LO: end_q[BYTE_W-1:0]       <= wdata;
            ADDR_DRV_HI: end_q[CNT_W-1:BYTE_W]   <= wdata[HI_W-1:0];
            ADDR_RST_LO: start_q[BYTE_W-1:0]     <= wdata;
            ADDR_RST_HI: start_q[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         ADDR_DRV_LO: rdata = end_q[BYTE_W-1:0];
         ADDR_DRV_HI: rdata = BYTE_W'(end_q[CNT_W-1:BYTE_W]);
         ADDR_RST_LO: rdata = start_q[BYTE_W-1:0];
         ADDR_RST_HI: rdata = BYTE_W'(start_q[CNT_W-1:BYTE_W]);
         default:     rdata = '0;
      endcase
   end

   assign drv_end   = end_q;
   assign rst_start = start_q;
endmodule

// File: rtl/lpg_edge.sv
module lpg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   output logic restart
);
   logic hs_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_d    <= 1'b1;
         restart <= 1'b0;
      end else begin
         hs_d    <= hsync_in;
         restart <= hs_d & ~hsync_in;
      end
   end

   AST_ONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart); // R8
endmodule

// File: rtl/lpg_timer.sv
module lpg_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] drv_end,
   input  logic [CNT_W-1:0] rst_start,
   output logic [CNT_W-1:0] cnt,
   output logic             run,
   output logic [CNT_W-1:0] end_act,
   output logic [CNT_W-1:0] start_act
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         run       <= 1'b0;
         end_act   <= '0;
         start_act <= '0;
      end else if (restart) begin
         cnt       <= '0;
         run       <= 1'b1;
         end_act   <= drv_end;
         start_act <= rst_start;
      end else if (run && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0 && run)); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && run && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R6
   AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> ($stable(end_act) && $stable(start_act))); // R7
endmodule

// File: rtl/lpg_window.sv
module lpg_window #(
   parameter int CNT_W     = 10,
   parameter int RESTORE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             run,
   input  logic [CNT_W-1:0] end_act,
   input  logic [CNT_W-1:0] start_act,
   output logic             drive_out,
   output logic             restore_out
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W:0]   WIN_EXT = (CNT_W+1)'(RESTORE_W);

   initial begin
      if (RESTORE_W < 0 || RESTORE_W >= (1 << CNT_W))
         $error("lpg_window: RESTORE_W out of range");
   end

   assign drive_out = run && (cnt < end_act);

   generate
      if (RESTORE_W == 0) begin : g_no_restore
         assign restore_out = 1'b0;
      end else begin : g_restore
         logic [CNT_W:0] lo_ext, hi_ext, c_ext;
         assign lo_ext = {1'b0, start_act};
         assign hi_ext = lo_ext + WIN_EXT;
         assign c_ext  = {1'b0, cnt};
         assign restore_out = run && (cnt != CNT_MAX) &&
                              (c_ext >= lo_ext) && (c_ext < hi_ext);
      end
   endgenerate

   AST_DRV_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_out) |-> (cnt == end_act)); // R4
   AST_DRV_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_out) |-> (cnt == '0)); // R3
   AST_RST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_out) |-> (cnt == start_act)); // R5
   AST_QUIET_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) |-> !restore_out); // R6
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
   import lpg_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int RESTORE_W = 16,
   parameter int DRV_RESET = 32,
   parameter int RST_RESET = 55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hsync_in,
   input  logic       cfg_we,
   input  logic [7:0] cfg_addr,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   output logic       drive_out,
   output logic       restore_out
);
   logic [CNT_W-1:0] drv_end, rst_start, cnt, end_act, start_act;
   logic             restart, run;

   lpg_regs #(.CNT_W(CNT_W), .DRV_RESET(DRV_RESET), .RST_RESET(RST_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .drv_end(drv_end), .rst_start(rst_start));

   lpg_edge u_edge (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .restart(restart));

   lpg_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .drv_end(drv_end),
      .rst_start(rst_start), .cnt(cnt), .run(run), .end_act(end_act),
      .start_act(start_act));

   lpg_window #(.CNT_W(CNT_W), .RESTORE_W(RESTORE_W)) u_window (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .run(run), .end_act(end_act),
      .start_act(start_act), .drive_out(drive_out), .restore_out(restore_out));
endmodule

// File: tb/line_pulse_gen_test.sv
module line_pulse_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int WIN = 16;
   localparam int CMAX = 1023;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_in = 1'b1;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_addr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       drive_out, restore_out;

   int n_chk = 0;
   int n_fail = 0;
   int end_m = 32;
   int start_m = 55;

   typedef struct {
      bit    drv;
      bit    rst;
      int    k;
      string tag;
   } exp_t;
   exp_t sb[$];

   line_pulse_gen uut (
      .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .drive_out(drive_out), .restore_out(restore_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle, away from the active edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(drive_out == e.drv, $sformatf("%s drive k=%0d", e.tag, e.k), drive_out, e.drv);
         check(restore_out == e.rst, $sformatf("%s restore k=%0d", e.tag, e.k), restore_out, e.rst);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (a)
         8'h0E: end_m   = (end_m & 32'h300) | d;
         8'h0F: end_m   = (end_m & 32'h0FF) | (int'(d[1:0]) << 8);
         8'h12: start_m = (start_m & 32'h300) | d;
         8'h13: start_m = (start_m & 32'h0FF) | (int'(d[1:0]) << 8);
         default: ;
      endcase
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(cfg_rdata == exp, tag, cfg_rdata, exp);
   endtask

   // driver: one line; expectations use the settings in force at its start
   task automatic line(input int len, input int low_len, input string tag);
      int e_end, e_st;
      e_end = end_m;
      e_st  = start_m;
      @(negedge clk);
      hsync_in = 1'b0;
      @(posedge clk);   // P0: edge sampled
      @(posedge clk);   // P1: count becomes 0
      for (int k = 0; k < len; k++) begin
         exp_t e;
         int   ke;
         ke = (k > CMAX) ? CMAX : k;
         e.drv = (ke < e_end);
         e.rst = (ke >= e_st) && (ke < e_st + WIN) && (ke != CMAX);
         e.k   = k;
         e.tag = tag;
         sb.push_back(e);
      end
      repeat (low_len) @(negedge clk);
      hsync_in = 1'b1;
      wait (sb.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(drive_out == 1'b0, "R1 drive low after reset", drive_out, 0);
      check(restore_out == 1'b0, "R1 restore low after reset", restore_out, 0);
      rd_check(8'h0E, 8'h20, "R1 drive end lo reset");
      rd_check(8'h0F, 8'h00, "R1 drive end hi reset");
      rd_check(8'h12, 8'h37, "R1 restore start lo reset");
      rd_check(8'h13, 8'h00, "R1 restore start hi reset");
      repeat (20) @(negedge clk);
      check(drive_out == 1'b0 && restore_out == 1'b0, "R1 idle before first sync",
            {drive_out, restore_out}, 0);
      rd_check(8'h05, 8'h00, "R2 unmapped address");

      // R3 R4 R5 default settings
      line(90, 4, "R3/R4/R5 default");

      // R2 masking and split
      wr(8'h0F, 8'hFF);
      rd_check(8'h0F, 8'h03, "R2 drive hi masked");
      wr(8'h0E, 8'h05);
      rd_check(8'h0E, 8'h05, "R2 drive lo");
      wr(8'h13, 8'hFE);
      rd_check(8'h13, 8'h02, "R2 restore hi masked");
      wr(8'h12, 8'hA5);
      rd_check(8'h12, 8'hA5, "R2 restore lo");
      wr(8'h0F, 8'h00); wr(8'h0E, 8'h0A);
      wr(8'h13, 8'h00); wr(8'h12, 8'h03);
      line(30, 2, "R4/R5 end10 start3");

      // R4 zero end time
      wr(8'h0E, 8'h00);
      line(25, 2, "R4 end0");

      // R7 deferred writes
      wr(8'h0E, 8'd40); wr(8'h12, 8'd20);
      fork
         line(70, 3, "R7 line under way");
         begin
            repeat (6) @(negedge clk);
            wr(8'h0E, 8'd5);
            wr(8'h12, 8'd0);
         end
      join
      line(30, 3, "R7 next line");

      // R6 saturation, R8 long low sync
      wr(8'h0E, 8'd12); wr(8'h13, 8'h03); wr(8'h12, 8'hF2);
      line(1100, 200, "R6/R8 saturate");
      check(drive_out == 1'b0 && restore_out == 1'b0, "R6 quiet at ceiling",
            {drive_out, restore_out}, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule